// File: doc/BRIEF.md
# Prescaled Watchdog Timer with Early-Warning Interrupt

This block is a watchdog timer controlled through one memory-mapped control and status word. Software writes the word to choose a clock divider and an interval, and to enable the timer, the early-warning interrupt and the system reset request. It later writes the kick bit to keep the system alive. While enabled, a prescaler divides the clock into timer ticks and a tick counter climbs toward a timeout chosen by the two select fields. A fixed number of ticks before the timeout the block raises a sticky warning flag, which can drive an interrupt. At the timeout it pulses a reset request and records that in a second sticky flag.

The reset request goes to an external reset controller. The block's own `rst_n` is the power-on reset only, so the reset flag survives a watchdog-caused reset and software can see why the system restarted. Both flags are write-one-to-clear. Writing zero to the whole word stops the timer.

Top module: `prewarn_watchdog`

## Requirements
- R1: After power-on reset the control word reads 0x000, `irq` is 0 and `rst_req` is 0.
- R2: The control word layout is: bits 11:10 divider select, bit 7 enable, bit 6 interrupt enable, bits 5:4 interval select, bit 3 warning flag, bit 2 reset flag, bit 1 reset enable, bit 0 kick. Bit 0 and bits 9:8 always read 0, and bits above 11 read 0.
- R3: A timer tick lasts 2^(DIV_STEP*div) clocks. The timeout is 2^(BASE_EXP+2*isel) ticks, so each interval step multiplies it by four and divider code 2 gives eight times code 1 (DIV_STEP=3). Expiry falls exactly that many clocks after the write that restarted the count, and the count then wraps and runs again.
- R4: The warning flag sets exactly WARN_TICKS ticks before expiry.
- R5: The warning flag sets whether or not the interrupt is enabled. `irq` is the flag ANDed with the interrupt enable.
- R6: A write with the kick bit set while enable is written 1 restarts the prescaler and the count from zero.
- R7: Both flags are write-one-to-clear. Writing 0 to a flag leaves it unchanged, and a flag being set in the same cycle as a clear stays set.
- R8: If the reset enable is set at expiry, `rst_req` is high for exactly one clock and the reset flag sets. If the reset enable is clear, neither happens.
- R9: A write of all zeros stops the timer. No further warning or reset events occur, and the enable bit reads 0.
- R10: Enabling the timer from disabled, or changing the divider or interval select while it is enabled, restarts the count.
- R11: A write to any address other than REG_ADDR has no effect, and a read at any other address returns 0.
- R12: The reset flag stays set after expiry until power-on reset or a software clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| irq | output | 1 | Early-warning interrupt, level |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The embedded assertions check the following on every cycle:
- each reset request lasts a single clock and coincides with the reset flag;
- each clearing write leaves the prescaler and the count at zero;
- a stopped timer holds a zero count;
- each flag rises only one cycle after its own event.

The bench scenarios cover what needs a reference count or a sequence of register accesses:
- the exact clock offsets of warning and expiry for several divider and interval pairs;
- the restart caused by a kick or a select change;
- the write-one-to-clear behaviour and the ignored foreign addresses;
- the persistence of the reset flag.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // bit positions inside the control word; software decodes these
  localparam int unsigned B_KICK  = 0;
  localparam int unsigned B_RSTEN = 1;
  localparam int unsigned B_RFLAG = 2;
  localparam int unsigned B_WFLAG = 3;
  localparam int unsigned B_ISEL  = 4;
  localparam int unsigned B_IRQEN = 6;
  localparam int unsigned B_EN    = 7;
  localparam int unsigned B_DIV   = 10;
  localparam int unsigned CTRL_W  = 12;

  typedef struct packed {
    logic [1:0] div;
    logic       en;
    logic       irq_en;
    logic [1:0] isel;
    logic       rst_en;
  } wdt_cfg_t;

  // clocks per tick for a divider code
  function automatic int unsigned clocks_per_tick(int unsigned div, int unsigned step);
    return 32'd1 << (div * step);
  endfunction

  // ticks from restart to expiry for an interval code
  function automatic int unsigned ticks_to_expiry(int unsigned isel, int unsigned base_exp);
    return 32'd1 << (base_exp + 2 * isel);
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV_STEP = 3,
  localparam int unsigned PRE_W   = 3 * DIV_STEP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [1:0]       div,
  output logic             tick,
  output logic [PRE_W-1:0] pre_cnt
);
  import wdt_pkg::*;

  logic [PRE_W-1:0] wrap_tbl [4];

  // terminal value of the prescaler for each divider code
  for (genvar g = 0; g < 4; g++) begin : g_wrap
    assign wrap_tbl[g] = PRE_W'(clocks_per_tick(g, DIV_STEP) - 1);
  end

  logic at_wrap;
  assign at_wrap = (pre_cnt == wrap_tbl[div]);
  assign tick    = run && !clr && at_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pre_cnt <= '0;
    else if (clr || !run)  pre_cnt <= '0;
    else if (at_wrap)      pre_cnt <= '0;
    else                   pre_cnt <= pre_cnt + PRE_W'(1);
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned BASE_EXP   = 11,
  parameter int unsigned WARN_TICKS = 1024,
  localparam int unsigned CNT_W     = BASE_EXP + 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [1:0]       isel,
  input  logic             rst_en,
  output logic             warn_evt,
  output logic             expire_evt,
  output logic             rst_req,
  output logic [CNT_W-1:0] cnt
);
  import wdt_pkg::*;

  logic [CNT_W-1:0] last_tbl [4];
  logic [CNT_W-1:0] warn_tbl [4];

  // per-interval compare points: final count and warning count
  for (genvar g = 0; g < 4; g++) begin : g_cmp
    assign last_tbl[g] = CNT_W'(ticks_to_expiry(g, BASE_EXP) - 1);
    assign warn_tbl[g] = CNT_W'(ticks_to_expiry(g, BASE_EXP) - WARN_TICKS - 1);
  end

  assign warn_evt   = tick && (cnt == warn_tbl[isel]);
  assign expire_evt = tick && (cnt == last_tbl[isel]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (expire_evt) cnt <= '0;
    else if (tick)       cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= expire_evt && rst_en;
  end

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              warn_evt,
  input  logic              expire_evt,
  output wdt_pkg::wdt_cfg_t cfg,
  output logic              wflag,
  output logic              rflag,
  output logic              clr,
  output logic [DATA_W-1:0] bus_rdata
);
  import wdt_pkg::*;

  logic     hit, wr_hit;
  wdt_cfg_t nxt;
  logic     sel_change;
  logic     unused_wdata;

  assign hit    = (bus_addr == REG_ADDR);
  assign wr_hit = bus_wr && hit;

  assign nxt.div    = bus_wdata[B_DIV +: 2];
  assign nxt.en     = bus_wdata[B_EN];
  assign nxt.irq_en = bus_wdata[B_IRQEN];
  assign nxt.isel   = bus_wdata[B_ISEL +: 2];
  assign nxt.rst_en = bus_wdata[B_RSTEN];

  assign unused_wdata = ^{bus_wdata[DATA_W-1:CTRL_W], bus_wdata[9:8]};

  assign sel_change = (nxt.div != cfg.div) || (nxt.isel != cfg.isel);

  // clear the count on stop, kick, start from idle, or select change
  assign clr = wr_hit && (!nxt.en || bus_wdata[B_KICK] || !cfg.en || sel_change);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg <= '0;
    else if (wr_hit) cfg <= nxt;
  end

  // sticky flags: event sets, write-one clears, set wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wflag <= 1'b0;
      rflag <= 1'b0;
    end else begin
      wflag <= (wflag && !(wr_hit && bus_wdata[B_WFLAG])) || warn_evt;
      rflag <= (rflag && !(wr_hit && bus_wdata[B_RFLAG])) || (expire_evt && cfg.rst_en);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      bus_rdata[B_DIV +: 2]  = cfg.div;
      bus_rdata[B_EN]        = cfg.en;
      bus_rdata[B_IRQEN]     = cfg.irq_en;
      bus_rdata[B_ISEL +: 2] = cfg.isel;
      bus_rdata[B_WFLAG]     = wflag;
      bus_rdata[B_RFLAG]     = rflag;
      bus_rdata[B_RSTEN]     = cfg.rst_en;
    end
  end

  a_r5_wflag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wflag) |-> $past(warn_evt));

  a_r12_rflag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rflag) |-> $past(expire_evt && cfg.rst_en));

endmodule

// File: rtl/prewarn_watchdog.sv
module prewarn_watchdog #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0,
  parameter int unsigned DIV_STEP   = 3,
  parameter int unsigned BASE_EXP   = 11,
  parameter int unsigned WARN_TICKS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              rst_req
);
  import wdt_pkg::*;

  localparam int unsigned PRE_W = 3 * DIV_STEP;
  localparam int unsigned CNT_W = BASE_EXP + 7;

  wdt_cfg_t         cfg;
  logic             wflag, rflag, clr, tick, warn_evt, expire_evt;
  logic [PRE_W-1:0] pre_cnt;
  logic [CNT_W-1:0] cnt;

  wdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .warn_evt(warn_evt), .expire_evt(expire_evt),
    .cfg(cfg), .wflag(wflag), .rflag(rflag), .clr(clr), .bus_rdata(bus_rdata)
  );

  wdt_prescaler #(.DIV_STEP(DIV_STEP)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(cfg.en), .clr(clr), .div(cfg.div),
    .tick(tick), .pre_cnt(pre_cnt)
  );

  wdt_counter #(.BASE_EXP(BASE_EXP), .WARN_TICKS(WARN_TICKS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .isel(cfg.isel),
    .rst_en(cfg.rst_en), .warn_evt(warn_evt), .expire_evt(expire_evt),
    .rst_req(rst_req), .cnt(cnt)
  );

  assign irq = wflag && cfg.irq_en;

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  a_r8_req_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> rflag);

  a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0) && (pre_cnt == '0));

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.en && $past(!cfg.en)) |-> (cnt == '0) && !tick);

endmodule

// File: tb/tb_prewarn_watchdog.sv
module tb_prewarn_watchdog;

  localparam int unsigned AW = 8;
  localparam int unsigned DW = 32;
  localparam logic [AW-1:0] RA = 8'h10;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          bus_wr = 0;
  logic [AW-1:0] bus_addr = RA;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq, rst_req;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prewarn_watchdog #(.ADDR_W(AW), .DATA_W(DW), .REG_ADDR(RA), .DIV_STEP(3),
                     .BASE_EXP(5), .WARN_TICKS(16)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
  );

  // div, isel, clocks to warning, clocks to expiry
  localparam int VEC [7][4] = '{
    '{0, 0,   16,   32},
    '{0, 1,  112,  128},
    '{1, 0,  128,  256},
    '{2, 0, 1024, 2048},
    '{0, 2,  496,  512},
    '{1, 1,  896, 1024},
    '{0, 3, 2032, 2048}
  };

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic check(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk);
    #1 bus_wr = 0; bus_addr = RA;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = RA;
  endtask

  // counts edges after the last write; records warning and reset events
  task automatic measure(int maxn, output int first_irq, output int first_rst,
                         output int nrst, output int last_rst, output bit wide);
    bit prev = 0;
    first_irq = -1; first_rst = -1; nrst = 0; last_rst = -1; wide = 0;
    for (int n = 1; n <= maxn; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (irq && first_irq < 0) first_irq = n;
      if (rst_req) begin
        if (first_rst < 0) first_rst = n;
        if (prev) wide = 1;
        nrst++;
        last_rst = n;
      end
      prev = rst_req;
    end
  endtask

  function automatic logic [DW-1:0] cfg_word(int div, int isel);
    return DW'((div << 10) | (isel << 4) | 32'hC3);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired (run hung)");
    finish_run();
  end

  initial begin
    logic [DW-1:0] r;
    int fi, fr, nr, lr;
    bit wd;
    int exp_d1, exp_d2;
    exp_d1 = 0; exp_d2 = 0;

    repeat (5) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd(RA, r);
    check("R1 reg after reset", r, 0);
    check("R1 irq after reset", irq, 0);
    check("R1 rst_req after reset", rst_req, 0);

    // R2 field readback, kick reads 0
    wr(RA, 32'h0000_08B1);
    rd(RA, r);
    check("R2 readback fields", r, 32'h8B0);
    wr(RA, 32'hFFFF_F300);
    rd(RA, r);
    check("R2 unused bits read 0", r, 32'h0);
    wr(RA, 32'h0000_000C);

    // R5 flag without irq enable
    wr(RA, 32'h81);
    measure(20, fi, fr, nr, lr, wd);
    check("R5 irq stays low when disabled", fi, -1);
    rd(RA, r);
    check("R5 warning flag set", r, 32'h88);
    // R7 zero leaves flag; R9 stop
    wr(RA, 32'h0);
    rd(RA, r);
    check("R7 write 0 keeps flag / R9 enable off", r, 32'h08);
    measure(100, fi, fr, nr, lr, wd);
    check("R9 no reset after stop", nr, 0);
    rd(RA, r);
    check("R9 state unchanged after stop", r, 32'h08);
    wr(RA, 32'h08);
    rd(RA, r);
    check("R7 write 1 clears flag", r, 32'h0);

    // R8 reset enable clear
    wr(RA, 32'h81);
    measure(40, fi, fr, nr, lr, wd);
    check("R8 no reset when reset disabled", nr, 0);
    rd(RA, r);
    check("R8 reset flag stays 0", r, 32'h88);
    wr(RA, 32'h0C);

    // R6 kick restarts, R3 wrap
    wr(RA, 32'hC3);
    measure(20, fi, fr, nr, lr, wd);
    check("R4 warning at 16", fi, 16);
    wr(RA, 32'hC3);
    measure(70, fi, fr, nr, lr, wd);
    check("R6 expiry 32 after kick", fr, 32);
    check("R3 wrap two expiries", nr, 2);
    check("R3 second expiry at 64", lr, 64);
    wr(RA, 32'h0C);

    // R10 select change restarts
    wr(RA, 32'h93);
    measure(100, fi, fr, nr, lr, wd);
    check("R10 no early reset", nr, 0);
    wr(RA, 32'h82);
    measure(40, fi, fr, nr, lr, wd);
    check("R10 expiry 32 after select change", fr, 32);
    wr(RA, 32'h0C);

    // R11 foreign address
    wr(8'h14, 32'hC3);
    rd(RA, r);
    check("R11 foreign write ignored", r, 0);
    wr(RA, 32'h80);
    rd(8'h14, r);
    check("R11 foreign read zero", r, 0);
    wr(RA, 32'h0);
    measure(40, fi, fr, nr, lr, wd);
    check("R11 no reset from foreign write", nr, 0);

    // table walk: R3, R4, R8, R12
    for (int i = 0; i < 7; i++) begin
      wr(RA, 32'h0C);
      wr(RA, cfg_word(VEC[i][0], VEC[i][1]));
      measure(VEC[i][3] + 3, fi, fr, nr, lr, wd);
      check($sformatf("R4 warning vec%0d", i), fi, VEC[i][2]);
      check($sformatf("R3 expiry vec%0d", i), fr, VEC[i][3]);
      check($sformatf("R8 single pulse vec%0d", i), wd, 0);
      rd(RA, r);
      check($sformatf("R12 flags held vec%0d", i), r,
            (cfg_word(VEC[i][0], VEC[i][1]) & ~32'h1) | 32'h0C);
      if (i == 2) exp_d1 = fr;
      if (i == 3) exp_d2 = fr;
    end
    check("R3 divider code 2 is 8x code 1", exp_d2, 8 * exp_d1);

    // R12 reset flag cleared only by write one
    wr(RA, 32'h0);
    rd(RA, r);
    check("R12 reset flag survives stop", r, 32'h0C);
    wr(RA, 32'h04);
    rd(RA, r);
    check("R7 clear reset flag alone", r, 32'h08);

    finish_run();
  end

endmodule